// File: doc/BRIEF.md
# Protocol Header Interpreter with Safety-Gated Commands

This block is the receive-side protocol engine of one link channel. It watches the stream of received tokens, where a token is either a data byte or an end-of-packet marker. In protocol mode it treats the first four data bytes of every packet as a header. Byte 0 is the destination address, byte 1 the command and byte 2 the command argument. Byte 3 is carried but not interpreted. Every header byte is echoed to an acknowledge generator together with its position.

Once the fourth header byte arrives, the block judges the header against the channel address. A data command opens the path into the receive FIFO for the rest of the packet. A control command sends a one-cycle request to the built-in command executor, which drives a CPU reset line, a set of external signal lines and per-link reset pulses. Any bad header raises a coded error and the rest of the packet is dropped. Dangerous commands are gated by a one-shot arm flag: a dedicated command sets it, and carrying out any dangerous command clears it again. With protocol mode off, the interpreter is bypassed and every data byte goes straight to the FIFO.

Top module: `pkt_hdr_interp`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is 0 and the arm flag is clear. The first data byte after reset counts as header byte 0.
- R2: In protocol mode, the first four data bytes after an end marker (or after reset) appear on `hdr_valid`/`hdr_idx`/`hdr_data` one cycle after they arrive, with index 0 to 3. They are never forwarded.
- R3: If byte 0 equals `chan_addr` and byte 1 is 0x01 (data), each later data byte of the packet appears on `fwd_valid`/`fwd_data` one cycle after it arrives, until the next end marker.
- R4: A valid control command raises `cmd_req` for one cycle, in the same cycle as the echo of header byte 3, with `cmd_code` = byte 1 and `cmd_arg` = byte 2. Data bytes after a control header are dropped. Codes: 0x10 CPU reset assert, 0x11 CPU reset release, 0x20 signal set, 0x21 signal clear, 0x30 single link reset, 0x31 all-link reset, 0x40 arm.
- R5: If byte 0 differs from `chan_addr`, `err_code` shows 1 for one cycle, in the same cycle as the echo of byte 3, and the packet is dropped. This check takes priority over R6 and R7.
- R6: A command byte outside the list in R4, or a signal argument ≥ NSIG, or a link argument ≥ NLINK, gives `err_code` 2 with no request. The packet is dropped.
- R7: Commands 0x10, 0x30 and 0x31 are dangerous. If one arrives while the arm flag is clear, it gives `err_code` 3 with no request, and it does not act.
- R8: Command 0x40 sets `safe_armed` one cycle after its request. When a dangerous command is carried out, `safe_armed` clears one cycle after that request. Other commands leave the flag unchanged.
- R9: One cycle after a request, `cpu_reset` is set by 0x10 and cleared by 0x11. `ext_sig[arg]` is set by 0x20 and cleared by 0x21. These levels hold until changed by a later command.
- R10: One cycle after a request, 0x30 pulses `link_reset[arg]` for one cycle and 0x31 pulses every `link_reset` bit for one cycle.
- R11: An end marker arriving after 1 to 3 header bytes gives `err_code` 4 one cycle later. An end marker with no header bytes gives no error.
- R12: With `proto_mode` low, every data byte is forwarded one cycle after it arrives. There is no header echo, no request and no error, and the next protocol-mode byte counts as header byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proto_mode | input | 1 | 1 = interpret headers, 0 = bypass |
| chan_addr | input | 8 | Address of this channel |
| tok_valid | input | 1 | A token is present this cycle |
| tok_eop | input | 1 | The token is an end-of-packet marker |
| tok_data | input | 8 | Data byte of the token |
| fwd_valid | output | 1 | Byte written to the receive FIFO |
| fwd_data | output | 8 | Forwarded byte |
| hdr_valid | output | 1 | Header byte for the acknowledge generator |
| hdr_idx | output | 2 | Position of the header byte |
| hdr_data | output | 8 | Header byte value |
| cmd_req | output | 1 | One-cycle request to the executor |
| cmd_code | output | 8 | Command byte of the request |
| cmd_arg | output | 8 | Argument byte of the request |
| err_code | output | 3 | 0 none, 1 address, 2 command, 3 not armed, 4 short |
| cpu_reset | output | 1 | CPU reset line |
| ext_sig | output | NSIG | External signal lines |
| link_reset | output | NLINK | Per-link reset pulses |
| safe_armed | output | 1 | Arm flag for dangerous commands |

## Verification
Outputs fall into two timing groups. The header echo, forwarded data, request and error code are due one clock after the token that causes them. The executor's lines, the arm flag and the link pulses are due one clock after the request, which is two clocks after the last header byte. The bench applies one token per cycle and samples at the falling edge after each rising edge. Its reference model applies the previous step's request to the executor state in the current step, and it judges the arm flag as it stood before that update, so each output is compared in exactly the cycle it is due.

// File: rtl/phi_pkg.sv
package phi_pkg;
   localparam int HDR_LEN = 4;
   localparam logic [7:0] CMD_DATA     = 8'h01;
   localparam logic [7:0] CMD_RST_ON   = 8'h10;
   localparam logic [7:0] CMD_RST_OFF  = 8'h11;
   localparam logic [7:0] CMD_SIG_SET  = 8'h20;
   localparam logic [7:0] CMD_SIG_CLR  = 8'h21;
   localparam logic [7:0] CMD_LINK_RST = 8'h30;
   localparam logic [7:0] CMD_ALL_RST  = 8'h31;
   localparam logic [7:0] CMD_ARM      = 8'h40;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_ADDR   = 3'd1,
      ERR_CMD    = 3'd2,
      ERR_LOCKED = 3'd3,
      ERR_SHORT  = 3'd4
   } phi_err_e;

   typedef enum logic [1:0] {
      PH_HDR  = 2'd0,
      PH_FWD  = 2'd1,
      PH_DROP = 2'd2
   } phi_phase_e;

   typedef struct packed {
      logic     fwd;
      logic     req;
      phi_err_e err;
   } phi_verdict_t;
endpackage

// File: rtl/phi_decode.sv
module phi_decode
   import phi_pkg::*;
#(
   parameter int NSIG  = 4,
   parameter int NLINK = 3
) (
   input  logic [7:0]   chan_addr,
   input  logic [7:0]   addr_byte,
   input  logic [7:0]   cmd_byte,
   input  logic [7:0]   arg_byte,
   input  logic         armed,
   output phi_verdict_t verdict
);
   logic sig_ok;
   logic link_ok;

   assign sig_ok  = ({24'd0, arg_byte} < 32'(NSIG));
   assign link_ok = ({24'd0, arg_byte} < 32'(NLINK));

   always_comb begin
      verdict = '{fwd: 1'b0, req: 1'b0, err: ERR_NONE};
      if (addr_byte != chan_addr) begin
         verdict.err = ERR_ADDR;
      end else begin
         unique case (cmd_byte)
            CMD_DATA:                 verdict.fwd = 1'b1;
            CMD_RST_OFF, CMD_ARM:     verdict.req = 1'b1;
            CMD_SIG_SET, CMD_SIG_CLR: begin
               if (sig_ok) verdict.req = 1'b1;
               else        verdict.err = ERR_CMD;
            end
            CMD_LINK_RST: begin
               if (!link_ok)   verdict.err = ERR_CMD;
               else if (armed) verdict.req = 1'b1;
               else            verdict.err = ERR_LOCKED;
            end
            CMD_RST_ON, CMD_ALL_RST: begin
               if (armed) verdict.req = 1'b1;
               else       verdict.err = ERR_LOCKED;
            end
            default: verdict.err = ERR_CMD;
         endcase
      end
   end
endmodule

// File: rtl/phi_seq.sv
module phi_seq
   import phi_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         proto_mode,
   input  logic         tok_valid,
   input  logic         tok_eop,
   input  logic [7:0]   tok_data,
   input  phi_verdict_t verdict,
   output logic [7:0]   addr_byte,
   output logic [7:0]   cmd_byte,
   output logic [7:0]   arg_byte,
   output logic         fwd_valid,
   output logic [7:0]   fwd_data,
   output logic         hdr_valid,
   output logic [1:0]   hdr_idx,
   output logic [7:0]   hdr_data,
   output logic         cmd_req,
   output logic [7:0]   cmd_code,
   output logic [7:0]   cmd_arg,
   output logic [2:0]   err_code
);
   localparam int CNT_W = $clog2(HDR_LEN);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_LEN - 1);

   phi_phase_e     phase;
   logic [CNT_W-1:0] cnt;
   logic           data_tok;

   assign data_tok = tok_valid && !tok_eop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_HDR;
         cnt       <= '0;
         addr_byte <= '0;
         cmd_byte  <= '0;
         arg_byte  <= '0;
         fwd_valid <= 1'b0;
         fwd_data  <= '0;
         hdr_valid <= 1'b0;
         hdr_idx   <= '0;
         hdr_data  <= '0;
         cmd_req   <= 1'b0;
         cmd_code  <= '0;
         cmd_arg   <= '0;
         err_code  <= ERR_NONE;
      end else begin
         fwd_valid <= 1'b0;
         hdr_valid <= 1'b0;
         cmd_req   <= 1'b0;
         err_code  <= ERR_NONE;
         if (!proto_mode) begin
            phase <= PH_HDR;
            cnt   <= '0;
            if (data_tok) begin
               fwd_valid <= 1'b1;
               fwd_data  <= tok_data;
            end
         end else if (tok_valid && tok_eop) begin
            if (phase == PH_HDR && cnt != '0) err_code <= ERR_SHORT;
            phase <= PH_HDR;
            cnt   <= '0;
         end else if (data_tok) begin
            unique case (phase)
               PH_HDR: begin
                  hdr_valid <= 1'b1;
                  hdr_idx   <= 2'(cnt);
                  hdr_data  <= tok_data;
                  if (cnt == LAST_IDX) begin
                     phase    <= verdict.fwd ? PH_FWD : PH_DROP;
                     cmd_req  <= verdict.req;
                     cmd_code <= cmd_byte;
                     cmd_arg  <= arg_byte;
                     err_code <= verdict.err;
                  end else begin
                     cnt <= cnt + 1'b1;
                     if (cnt == CNT_W'(0)) addr_byte <= tok_data;
                     if (cnt == CNT_W'(1)) cmd_byte  <= tok_data;
                     if (cnt == CNT_W'(2)) arg_byte  <= tok_data;
                  end
               end
               PH_FWD: begin
                  fwd_valid <= 1'b1;
                  fwd_data  <= tok_data;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/phi_exec.sv
module phi_exec
   import phi_pkg::*;
#(
   parameter int NSIG  = 4,
   parameter int NLINK = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_req,
   input  logic [7:0]       cmd_code,
   input  logic [7:0]       cmd_arg,
   output logic             cpu_reset,
   output logic [NSIG-1:0]  ext_sig,
   output logic [NLINK-1:0] link_reset,
   output logic             safe_armed
);
   logic critical;
   assign critical = (cmd_code == CMD_RST_ON) || (cmd_code == CMD_LINK_RST) ||
                     (cmd_code == CMD_ALL_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_reset  <= 1'b0;
         safe_armed <= 1'b0;
      end else if (cmd_req) begin
         if (cmd_code == CMD_RST_ON)  cpu_reset <= 1'b1;
         if (cmd_code == CMD_RST_OFF) cpu_reset <= 1'b0;
         if (cmd_code == CMD_ARM)     safe_armed <= 1'b1;
         else if (critical)           safe_armed <= 1'b0;
      end
   end

   for (genvar g = 0; g < NSIG; g++) begin : g_sig
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ext_sig[g] <= 1'b0;
         end else if (cmd_req && cmd_arg == 8'(g)) begin
            if (cmd_code == CMD_SIG_SET) ext_sig[g] <= 1'b1;
            if (cmd_code == CMD_SIG_CLR) ext_sig[g] <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < NLINK; g++) begin : g_link
      always_ff @(posedge clk) begin
         if (!rst_n) link_reset[g] <= 1'b0;
         else        link_reset[g] <= cmd_req &&
                        ((cmd_code == CMD_LINK_RST && cmd_arg == 8'(g)) ||
                         (cmd_code == CMD_ALL_RST));
      end
   end
endmodule

// File: rtl/pkt_hdr_interp.sv
module pkt_hdr_interp
   import phi_pkg::*;
#(
   parameter int NSIG  = 4,
   parameter int NLINK = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             proto_mode,
   input  logic [7:0]       chan_addr,
   input  logic             tok_valid,
   input  logic             tok_eop,
   input  logic [7:0]       tok_data,
   output logic             fwd_valid,
   output logic [7:0]       fwd_data,
   output logic             hdr_valid,
   output logic [1:0]       hdr_idx,
   output logic [7:0]       hdr_data,
   output logic             cmd_req,
   output logic [7:0]       cmd_code,
   output logic [7:0]       cmd_arg,
   output logic [2:0]       err_code,
   output logic             cpu_reset,
   output logic [NSIG-1:0]  ext_sig,
   output logic [NLINK-1:0] link_reset,
   output logic             safe_armed
);
   if (NSIG < 1 || NSIG > 8) begin : g_bad_nsig
      $error("pkt_hdr_interp: NSIG must be 1..8");
   end
   if (NLINK < 1 || NLINK > 8) begin : g_bad_nlink
      $error("pkt_hdr_interp: NLINK must be 1..8");
   end

   phi_verdict_t verdict;
   logic [7:0]   addr_byte;
   logic [7:0]   cmd_byte;
   logic [7:0]   arg_byte;

   phi_decode #(.NSIG(NSIG), .NLINK(NLINK)) u_decode (
      .chan_addr (chan_addr),
      .addr_byte (addr_byte),
      .cmd_byte  (cmd_byte),
      .arg_byte  (arg_byte),
      .armed     (safe_armed),
      .verdict   (verdict)
   );

   phi_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .proto_mode (proto_mode),
      .tok_valid  (tok_valid),
      .tok_eop    (tok_eop),
      .tok_data   (tok_data),
      .verdict    (verdict),
      .addr_byte  (addr_byte),
      .cmd_byte   (cmd_byte),
      .arg_byte   (arg_byte),
      .fwd_valid  (fwd_valid),
      .fwd_data   (fwd_data),
      .hdr_valid  (hdr_valid),
      .hdr_idx    (hdr_idx),
      .hdr_data   (hdr_data),
      .cmd_req    (cmd_req),
      .cmd_code   (cmd_code),
      .cmd_arg    (cmd_arg),
      .err_code   (err_code)
   );

   phi_exec #(.NSIG(NSIG), .NLINK(NLINK)) u_exec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_req    (cmd_req),
      .cmd_code   (cmd_code),
      .cmd_arg    (cmd_arg),
      .cpu_reset  (cpu_reset),
      .ext_sig    (ext_sig),
      .link_reset (link_reset),
      .safe_armed (safe_armed)
   );
endmodule

// File: rtl/pkt_hdr_interp_chk.sv
module pkt_hdr_interp_chk #(
   parameter int NLINK = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             proto_mode,
   input logic             tok_valid,
   input logic             tok_eop,
   input logic             fwd_valid,
   input logic             hdr_valid,
   input logic [1:0]       hdr_idx,
   input logic             cmd_req,
   input logic [7:0]       cmd_code,
   input logic [2:0]       err_code,
   input logic             cpu_reset,
   input logic [NLINK-1:0] link_reset,
   input logic             safe_armed
);
   AST_FWD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(tok_valid && !tok_eop)); // R3
   AST_REQ_ON_LAST_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (hdr_valid && hdr_idx == 2'd3)); // R4
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) |=> (err_code == 3'd0)); // R5
   AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) |-> !cmd_req); // R7
   AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(safe_armed) |-> $past(cmd_req)); // R8
   AST_CPU_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_reset) |-> ($past(cmd_req) && $past(cmd_code) == 8'h10)); // R9
   AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (link_reset != '0) |=> (link_reset == '0)); // R10
   AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(proto_mode) |-> (!hdr_valid && !cmd_req && err_code == 3'd0)); // R12
endmodule

bind pkt_hdr_interp pkt_hdr_interp_chk #(.NLINK(NLINK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .proto_mode (proto_mode),
   .tok_valid  (tok_valid),
   .tok_eop    (tok_eop),
   .fwd_valid  (fwd_valid),
   .hdr_valid  (hdr_valid),
   .hdr_idx    (hdr_idx),
   .cmd_req    (cmd_req),
   .cmd_code   (cmd_code),
   .err_code   (err_code),
   .cpu_reset  (cpu_reset),
   .link_reset (link_reset),
   .safe_armed (safe_armed)
);

// File: tb/pkt_hdr_interp_tb_top.sv
module pkt_hdr_interp_tb_top;
   localparam int NSIG  = 4;
   localparam int NLINK = 3;
   localparam logic [7:0] CHAN = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic proto_mode = 1'b1;
   logic tok_valid = 1'b0;
   logic tok_eop = 1'b0;
   logic [7:0] tok_data = 8'h00;
   logic fwd_valid, hdr_valid, cmd_req, cpu_reset, safe_armed;
   logic [7:0] fwd_data, hdr_data, cmd_code, cmd_arg;
   logic [1:0] hdr_idx;
   logic [2:0] err_code;
   logic [NSIG-1:0] ext_sig;
   logic [NLINK-1:0] link_reset;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state
   int m_ph = 0;
   int m_cnt = 0;
   logic [7:0] m_b [0:2];
   logic m_arm = 1'b0;
   logic m_cpu = 1'b0;
   logic [NSIG-1:0] m_sig = '0;
   logic p_req = 1'b0;
   logic [7:0] p_code = 8'h00;
   logic [7:0] p_arg = 8'h00;

   always #5 clk = ~clk;

   pkt_hdr_interp #(.NSIG(NSIG), .NLINK(NLINK)) dut_i (
      .clk(clk), .rst_n(rst_n), .proto_mode(proto_mode), .chan_addr(CHAN),
      .tok_valid(tok_valid), .tok_eop(tok_eop), .tok_data(tok_data),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data), .hdr_valid(hdr_valid),
      .hdr_idx(hdr_idx), .hdr_data(hdr_data), .cmd_req(cmd_req),
      .cmd_code(cmd_code), .cmd_arg(cmd_arg), .err_code(err_code),
      .cpu_reset(cpu_reset), .ext_sig(ext_sig), .link_reset(link_reset),
      .safe_armed(safe_armed)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void judge(input logic [7:0] a, input logic [7:0] c,
                                 input logic [7:0] g, output logic fw,
                                 output logic rq, output logic [2:0] er);
      fw = 1'b0; rq = 1'b0; er = 3'd0;
      if (a != CHAN) er = 3'd1;
      else case (c)
         8'h01: fw = 1'b1;
         8'h11, 8'h40: rq = 1'b1;
         8'h20, 8'h21: if (g < 8'(NSIG)) rq = 1'b1; else er = 3'd2;
         8'h30: if (g >= 8'(NLINK)) er = 3'd2; else if (!m_arm) er = 3'd3; else rq = 1'b1;
         8'h10, 8'h31: if (!m_arm) er = 3'd3; else rq = 1'b1;
         default: er = 3'd2;
      endcase
   endfunction

   function automatic string err_tag(input logic [2:0] e, input logic pm);
      if (!pm) return "R12 err";
      case (e)
         3'd2: return "R6 err";
         3'd3: return "R7 err";
         3'd4: return "R11 err";
         default: return "R5 err";
      endcase
   endfunction

   task automatic step(input logic v, input logic e, input logic [7:0] d, input logic pm);
      logic x_fwd, x_hdr, x_req, fw, rq;
      logic [7:0] x_fd, x_hd, x_code, x_arg;
      logic [1:0] x_idx;
      logic [2:0] x_err, er;
      logic [NLINK-1:0] x_link;
      tok_valid = v; tok_eop = e; tok_data = d; proto_mode = pm;
      @(negedge clk);
      x_fwd = 0; x_hdr = 0; x_req = 0; x_fd = 0; x_hd = 0; x_code = 0;
      x_arg = 0; x_idx = 0; x_err = 0;
      if (!pm) begin
         m_ph = 0; m_cnt = 0;
         if (v && !e) begin x_fwd = 1; x_fd = d; end
      end else if (v) begin
         if (e) begin
            if (m_ph == 0 && m_cnt != 0) x_err = 3'd4;
            m_ph = 0; m_cnt = 0;
         end else if (m_ph == 0) begin
            x_hdr = 1; x_idx = 2'(m_cnt); x_hd = d;
            if (m_cnt < 3) begin m_b[m_cnt] = d; m_cnt++; end
            else begin
               judge(m_b[0], m_b[1], m_b[2], fw, rq, er);
               m_ph = fw ? 1 : 2;
               x_req = rq; x_code = m_b[1]; x_arg = m_b[2]; x_err = er;
            end
         end else if (m_ph == 1) begin
            x_fwd = 1; x_fd = d;
         end
      end
      x_link = '0;
      if (p_req) begin
         case (p_code)
            8'h10: begin m_cpu = 1; m_arm = 0; end
            8'h11: m_cpu = 0;
            8'h20: m_sig[p_arg[1:0]] = 1'b1;
            8'h21: m_sig[p_arg[1:0]] = 1'b0;
            8'h30: begin x_link[p_arg[1:0]] = 1'b1; m_arm = 0; end
            8'h31: begin x_link = '1; m_arm = 0; end
            8'h40: m_arm = 1;
            default: ;
         endcase
      end
      p_req = x_req; p_code = x_code; p_arg = x_arg;
      chk(pm ? "R3 fwd_valid" : "R12 fwd_valid", 32'(fwd_valid), 32'(x_fwd));
      if (x_fwd) chk(pm ? "R3 fwd_data" : "R12 fwd_data", 32'(fwd_data), 32'(x_fd));
      chk(pm ? "R2 hdr_valid" : "R12 hdr_valid", 32'(hdr_valid), 32'(x_hdr));
      if (x_hdr) begin
         chk("R2 hdr_idx", 32'(hdr_idx), 32'(x_idx));
         chk("R2 hdr_data", 32'(hdr_data), 32'(x_hd));
      end
      chk(pm ? "R4 cmd_req" : "R12 cmd_req", 32'(cmd_req), 32'(x_req));
      if (x_req) chk("R4 cmd_code_arg", {16'd0, cmd_code, cmd_arg}, {16'd0, x_code, x_arg});
      chk(err_tag(x_err, pm), 32'(err_code), 32'(x_err));
      chk("R9 cpu_reset", 32'(cpu_reset), 32'(m_cpu));
      chk("R9 ext_sig", 32'(ext_sig), 32'(m_sig));
      chk("R10 link_reset", 32'(link_reset), 32'(x_link));
      chk("R8 safe_armed", 32'(safe_armed), 32'(m_arm));
   endtask

   task automatic pkt(input logic [7:0] a, input logic [7:0] c, input logic [7:0] g,
                      input int ndata, input int hdr_n);
      step(1, 0, a, 1);
      if (hdr_n > 1) step(1, 0, c, 1);
      if (hdr_n > 2) step(1, 0, g, 1);
      if (hdr_n > 3) step(1, 0, 8'hC3, 1);
      for (int i = 0; i < ndata; i++) step(1, 0, 8'($urandom), 1);
      step(1, 1, 8'h00, 1);
      step(0, 0, 8'h00, 1);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed_set;
      logic [7:0] c;
      seed_set = $urandom(32'd715);
      repeat (3) @(negedge clk);
      // R1: outputs idle under reset
      chk("R1 reset outputs", {fwd_valid, hdr_valid, cmd_req, err_code, cpu_reset,
          ext_sig, link_reset, safe_armed}, 32'd0);
      rst_n = 1'b1;
      step(0, 0, 0, 1);
      // directed corner cases
      pkt(CHAN, 8'h01, 8'h00, 3, 4);       // R3 data forwarding
      pkt(8'h11, 8'h01, 8'h00, 2, 4);      // R5 address mismatch
      pkt(CHAN, 8'h77, 8'h00, 1, 4);       // R6 unknown command
      pkt(CHAN, 8'h20, 8'h09, 0, 4);       // R6 signal argument out of range
      pkt(CHAN, 8'h10, 8'h00, 0, 4);       // R7 dangerous while not armed
      pkt(CHAN, 8'h40, 8'h00, 0, 4);       // R8 arm
      pkt(CHAN, 8'h10, 8'h00, 2, 4);       // R9 CPU reset, R8 auto clear
      pkt(CHAN, 8'h11, 8'h00, 0, 4);       // R9 release
      pkt(CHAN, 8'h20, 8'h02, 0, 4);       // R9 signal set
      pkt(CHAN, 8'h21, 8'h02, 0, 4);       // R9 signal clear
      pkt(CHAN, 8'h40, 8'h00, 0, 4);
      pkt(CHAN, 8'h30, 8'h01, 0, 4);       // R10 single link
      pkt(CHAN, 8'h40, 8'h00, 0, 4);
      pkt(CHAN, 8'h31, 8'h00, 0, 4);       // R10 all links
      pkt(CHAN, 8'h31, 8'h00, 0, 4);       // R7 arm consumed
      pkt(CHAN, 8'h01, 8'h00, 0, 2);       // R11 short packet
      step(1, 1, 0, 1);                    // R11 empty packet, no error
      for (int i = 0; i < 4; i++) step(1, 0, 8'(8'hA0 + i), 0); // R12 bypass
      step(1, 1, 0, 0);
      pkt(CHAN, 8'h01, 8'h00, 1, 4);       // R2 header restarts after bypass
      // constrained random traffic
      for (int n = 0; n < 300; n++) begin
         case ($urandom % 9)
            0: c = 8'h01; 1: c = 8'h10; 2: c = 8'h11; 3: c = 8'h20; 4: c = 8'h21;
            5: c = 8'h30; 6: c = 8'h31; 7: c = 8'h40; default: c = 8'($urandom);
         endcase
         if ($urandom % 8 == 0) begin
            for (int i = 0; i < 3; i++) step(1, 0, 8'($urandom), 0);
            step(1, 1, 0, 0);
         end else begin
            pkt(($urandom % 4 == 0) ? 8'($urandom) : CHAN, c, 8'($urandom % 6),
                int'($urandom % 5), ($urandom % 10 == 0) ? int'($urandom % 3) + 1 : 4);
         end
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule